// File: doc/BRIEF.md
# Column Command Packet Receiver

This block sits at the column-control input of a memory device. It watches a 5-bit column request lane that is sampled once per clock. A frame is 8 samples (40 bits) long. It starts on the first sample whose top lane bit is high. Each frame carries two parts. The leading part is a column command (device, bank, column, opcode). The trailing part is a byte-mask word or an independent extended command, chosen by a select bit. The two parts are checked against the device's own ID separately. A single frame can therefore produce a column command, an extended command, both, or neither.

A byte-mask word never applies to the command in its own frame. It applies to the write command that was accepted a programmable number of frames earlier. That number is set on `rtr_slots_i`. The block keeps a short shift queue of accepted writes, advanced once per frame. When a mask arrives, it reads the queue entry at the programmed distance. If that entry holds a write, the mask is issued with the write's bank and column. If it does not, an orphan flag pulses and the mask is dropped. The block does not move data, check bank timing or execute any command.

Top module: `col_rx`

## Requirements
- R1: Framing. While idle, a sample with `col_i[4]`=0 is ignored. A sample with `col_i[4]`=1 is the first of a frame, and the following 7 samples are taken whatever their value. A new frame may start on the sample directly after the eighth. Frame bit 39 is sample 1 bit 4, and each later sample fills the next five lower bits.
- R2: Column-command layout within the frame: device [38:34], bank [32:29], column [26:21], opcode [20:17]. Bits 33, 28 and 27 are reserved and ignored.
- R3: When the column-command device equals `dev_id_i`, `cmd_valid_o` pulses for one clock with bank, column and opcode. The pulse comes in the cycle after the first rising edge that follows the edge capturing the eighth sample.
- R4: A column command whose device differs from `dev_id_i` produces no `cmd_valid_o` pulse. Reserved bits have no effect on any output field.
- R5: Frame bit 16 selects the trailing part: 1 means a byte-mask word and 0 means an extended command. Mask layout: lane-A mask at [15:8] and lane-B mask at [7:0]. Extended-command layout: device [15:11], bank [9:6], opcode [5:1]. Bits 10 and 0 are reserved.
- R6: An extended command pulses `xcmd_valid_o` only when its own device field equals `dev_id_i`, independent of the column-command device. It never pulses on a mask frame.
- R7: A mask frame is paired with the frame N frames earlier, where N is `rtr_slots_i`. If that earlier frame held an accepted write, `mask_valid_o` pulses with that write's bank and column. `mask_we_o[7:0]` is the lane-A mask and `mask_we_o[15:8]` is the lane-B mask. A 1 means write, and bit 0 of each lane is its earliest byte.
- R8: If the paired frame held no accepted write, `mask_orphan_o` pulses and `mask_valid_o` stays low.
- R9: A frame counts as an accepted write only if its column-command device matches and its opcode is 4'b0100. Reads and other-device writes are never paired.
- R10: `rtr_slots_i`=0 acts as 1. Values above MAX_RTR (4) act as MAX_RTR.
- R11: During and after reset all strobes are low and the write queue is empty, so a mask that arrives before any write is an orphan.
- R12: `mask_valid_o` and `xcmd_valid_o` never pulse together, nor do `mask_valid_o` and `mask_orphan_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one lane sample per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_id_i | input | 5 | This device's ID |
| rtr_slots_i | input | 3 | Mask-to-write distance in frames |
| col_i | input | 5 | Column request lane |
| cmd_valid_o | output | 1 | Column command strobe |
| cmd_bank_o | output | 4 | Column command bank |
| cmd_col_o | output | 6 | Column command column address |
| cmd_op_o | output | 4 | Column command opcode |
| mask_valid_o | output | 1 | Byte-mask strobe |
| mask_we_o | output | 16 | Byte write enables, lane A low byte |
| mask_bank_o | output | 4 | Bank of the paired write |
| mask_col_o | output | 6 | Column of the paired write |
| mask_orphan_o | output | 1 | Mask arrived with no paired write |
| xcmd_valid_o | output | 1 | Extended command strobe |
| xcmd_bank_o | output | 4 | Extended command bank |
| xcmd_op_o | output | 5 | Extended command opcode |

## Verification
The hardest case to reach is a mask landing on exactly the right queue slot. The pairing depends on the history of several earlier frames, not on the current one. The stimulus table mixes accepted writes, reads, other-device writes and filler frames, so masks land on both filled and empty slots. A bench-side queue model supplies the expected bank and column. Directed runs then cover back-to-back frames, the clamped delay settings with filler frames between write and mask, and a reset that must discard a pending write.

// File: rtl/col_rx_pkg.sv
// Package: shared field types and constants for the column packet receiver.
// Assumes a fixed 40-bit frame layout; positions are used by the decoder only.
package col_rx_pkg;
    localparam int LANE_W    = 5;
    localparam int SAMPLES   = 8;
    localparam int PKT_W     = LANE_W * SAMPLES;
    localparam int DEV_W     = 5;
    localparam int BANK_W    = 4;
    localparam int COL_W     = 6;
    localparam int COP_W     = 4;
    localparam int XOP_W     = 5;
    localparam int MASK_W    = 16;
    localparam logic [COP_W-1:0] COP_WRITE = 4'b0100;

    typedef struct packed {
        logic [DEV_W-1:0]  dev;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic [COP_W-1:0]  op;
    } colc_t;

    typedef struct packed {
        logic [DEV_W-1:0]  dev;
        logic [BANK_W-1:0] bank;
        logic [XOP_W-1:0]  op;
    } colx_t;

    typedef struct packed {
        logic              vld;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
    } pend_t;
endpackage

// File: rtl/col_rx_framer.sv
// Module: col_rx_framer
// Hunts for a start bit on the top lane bit, then gathers SAMPLES lane words
// into one frame and pulses done_o for one cycle once the last is captured.
// Assumes one lane sample per clock and no gap inside a frame.
module col_rx_framer #(
    parameter int LANE_W  = 5,
    parameter int SAMPLES = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LANE_W-1:0]           lane_i,
    output logic [LANE_W*SAMPLES-1:0]   pkt_o,
    output logic                        done_o
);
    localparam int PKT_W = LANE_W * SAMPLES;
    localparam int CNT_W = (SAMPLES > 2) ? $clog2(SAMPLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic [PKT_W-1:0] shift_q;

    assign pkt_o = shift_q;

    // Frame capture: start on the start bit, shift in samples, flag the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            shift_q <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (!busy_q) begin
                if (lane_i[LANE_W-1]) begin
                    busy_q  <= 1'b1;
                    cnt_q   <= CNT_W'(1);
                    shift_q <= {shift_q[PKT_W-LANE_W-1:0], lane_i};
                end
            end else begin
                shift_q <= {shift_q[PKT_W-LANE_W-1:0], lane_i};
                if (cnt_q == LAST) begin
                    busy_q <= 1'b0;
                    cnt_q  <= '0;
                    done_o <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/col_rx_field_dec.sv
// Module: col_rx_field_dec
// Purely combinational split of a captured frame into its command part and
// its trailing mask or extended-command part, with per-part ID matching.
// Assumes the 40-bit layout in the package; reserved bits are dropped.
module col_rx_field_dec
    import col_rx_pkg::*;
(
    input  logic [PKT_W-1:0]  pkt_i,
    input  logic [DEV_W-1:0]  my_dev_i,
    output colc_t             colc_o,
    output logic              colc_hit_o,
    output logic              is_write_o,
    output logic              mask_sel_o,
    output logic [MASK_W-1:0] mask_o,
    output colx_t             colx_o,
    output logic              colx_hit_o
);
    logic unused_rsv;

    // Discarded bits: start flag and reserved positions.
    assign unused_rsv = ^{pkt_i[39], pkt_i[33], pkt_i[28:27], pkt_i[10], pkt_i[0]};

    // Field extraction and ID comparison for both parts.
    always_comb begin
        colc_o.dev  = pkt_i[38:34];
        colc_o.bank = pkt_i[32:29];
        colc_o.col  = pkt_i[26:21];
        colc_o.op   = pkt_i[20:17];
        mask_sel_o  = pkt_i[16];
        mask_o      = {pkt_i[7:0], pkt_i[15:8]};
        colx_o.dev  = pkt_i[15:11];
        colx_o.bank = pkt_i[9:6];
        colx_o.op   = pkt_i[5:1];
        colc_hit_o  = (colc_o.dev == my_dev_i);
        colx_hit_o  = (colx_o.dev == my_dev_i);
        is_write_o  = colc_hit_o && (colc_o.op == COP_WRITE);
    end
endmodule

// File: rtl/col_rx_wr_queue.sv
// Module: col_rx_wr_queue
// Shift queue of per-frame write records, advanced once per frame. tap_o
// shows the record pushed delay_i frames ago (0 acts as 1, above DEPTH as DEPTH).
// Assumes adv_i pulses once per received frame.
module col_rx_wr_queue
    import col_rx_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  pend_t            push_i,
    input  logic [SEL_W-1:0] delay_i,
    output pend_t            tap_o
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    pend_t            stg_q [DEPTH];
    logic [IDX_W-1:0] idx;

    // Delay clamp and tap selection.
    always_comb begin
        if (delay_i == '0)
            idx = '0;
        else if (int'(delay_i) > DEPTH)
            idx = IDX_W'(DEPTH - 1);
        else
            idx = IDX_W'(int'(delay_i) - 1);
        tap_o = stg_q[idx];
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        // One queue stage: clear on reset, take the previous stage per frame.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stg_q[g] <= '0;
            else if (adv_i)
                stg_q[g] <= (g == 0) ? push_i : stg_q[(g == 0) ? 0 : g-1];
        end
    end
endmodule

// File: rtl/col_rx.sv
// Module: col_rx (top)
// Column packet receiver: frames the lane, decodes both parts, pairs masks
// with earlier writes and registers one-cycle strobes with their fields.
// Assumes dev_id_i and rtr_slots_i are stable while frames arrive.
module col_rx
    import col_rx_pkg::*;
#(
    parameter int MAX_RTR = 4,
    parameter int RTR_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        dev_id_i,
    input  logic [RTR_W-1:0]  rtr_slots_i,
    input  logic [4:0]        col_i,
    output logic              cmd_valid_o,
    output logic [3:0]        cmd_bank_o,
    output logic [5:0]        cmd_col_o,
    output logic [3:0]        cmd_op_o,
    output logic              mask_valid_o,
    output logic [15:0]       mask_we_o,
    output logic [3:0]        mask_bank_o,
    output logic [5:0]        mask_col_o,
    output logic              mask_orphan_o,
    output logic              xcmd_valid_o,
    output logic [3:0]        xcmd_bank_o,
    output logic [4:0]        xcmd_op_o
);
    logic [PKT_W-1:0]  pkt;
    logic              frame_done;
    colc_t             colc;
    colx_t             colx;
    logic              colc_hit, colx_hit, is_write, mask_sel;
    logic [MASK_W-1:0] mask;
    pend_t             push_rec, tap_rec;

    col_rx_framer #(.LANE_W(LANE_W), .SAMPLES(SAMPLES)) u_framer (
        .clk    (clk),
        .rst_n  (rst_n),
        .lane_i (col_i),
        .pkt_o  (pkt),
        .done_o (frame_done)
    );

    col_rx_field_dec u_dec (
        .pkt_i      (pkt),
        .my_dev_i   (dev_id_i),
        .colc_o     (colc),
        .colc_hit_o (colc_hit),
        .is_write_o (is_write),
        .mask_sel_o (mask_sel),
        .mask_o     (mask),
        .colx_o     (colx),
        .colx_hit_o (colx_hit)
    );

    // Record for this frame: a write only if accepted by this device.
    always_comb begin
        push_rec.vld  = is_write;
        push_rec.bank = colc.bank;
        push_rec.col  = colc.col;
    end

    col_rx_wr_queue #(.DEPTH(MAX_RTR), .SEL_W(RTR_W)) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (frame_done),
        .push_i  (push_rec),
        .delay_i (rtr_slots_i),
        .tap_o   (tap_rec)
    );

    // Output register: strobes for one cycle, fields loaded per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid_o   <= 1'b0;
            cmd_bank_o    <= '0;
            cmd_col_o     <= '0;
            cmd_op_o      <= '0;
            mask_valid_o  <= 1'b0;
            mask_we_o     <= '0;
            mask_bank_o   <= '0;
            mask_col_o    <= '0;
            mask_orphan_o <= 1'b0;
            xcmd_valid_o  <= 1'b0;
            xcmd_bank_o   <= '0;
            xcmd_op_o     <= '0;
        end else begin
            cmd_valid_o   <= frame_done && colc_hit;
            mask_valid_o  <= frame_done && mask_sel && tap_rec.vld;
            mask_orphan_o <= frame_done && mask_sel && !tap_rec.vld;
            xcmd_valid_o  <= frame_done && !mask_sel && colx_hit;
            if (frame_done) begin
                cmd_bank_o  <= colc.bank;
                cmd_col_o   <= colc.col;
                cmd_op_o    <= colc.op;
                mask_we_o   <= mask;
                mask_bank_o <= tap_rec.bank;
                mask_col_o  <= tap_rec.col;
                xcmd_bank_o <= colx.bank;
                xcmd_op_o   <= colx.op;
            end
        end
    end
endmodule

// File: rtl/col_rx_chk.sv
// Module: col_rx_chk
// Checker bound into col_rx: strobe spacing, exclusivity and framing order.
module col_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic frame_done,
    input logic cmd_valid_o,
    input logic mask_valid_o,
    input logic mask_orphan_o,
    input logic xcmd_valid_o
);
    assert_done_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    assert_strobe_after_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o || xcmd_valid_o || mask_valid_o || mask_orphan_o) |-> $past(frame_done));

    assert_cmd_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);

    assert_xcmd_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xcmd_valid_o |=> !xcmd_valid_o);

    assert_orphan_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mask_valid_o && mask_orphan_o));

    assert_mask_xcmd_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mask_valid_o && xcmd_valid_o));
endmodule

bind col_rx col_rx_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_done    (frame_done),
    .cmd_valid_o   (cmd_valid_o),
    .mask_valid_o  (mask_valid_o),
    .mask_orphan_o (mask_orphan_o),
    .xcmd_valid_o  (xcmd_valid_o)
);

// File: tb/col_rx_tb.sv
`timescale 1ns/1ps
module col_rx_tb;
    localparam logic [4:0] DEV = 5'h0B;
    localparam logic [4:0] OTH = 5'h05;
    // Vector: cdev, bank, col, op, m, payload, expected {cmd, xcmd, mask, orphan}
    localparam int VW = 5+4+6+4+1+16+4;
    localparam int NV = 8;
    localparam logic [VW-1:0] VEC [NV] = '{
        {DEV, 4'h3, 6'd10, 4'h4, 1'b0, 16'h2800, 4'b1000},
        {DEV, 4'h5, 6'd21, 4'h2, 1'b0, 16'h59D2, 4'b1100},
        {OTH, 4'h1, 6'd1,  4'h4, 1'b1, 16'hA53C, 4'b0010},
        {DEV, 4'h9, 6'd63, 4'h4, 1'b1, 16'hFF00, 4'b1001},
        {OTH, 4'h6, 6'd7,  4'h4, 1'b0, 16'h587E, 4'b0100},
        {DEV, 4'h2, 6'd0,  4'h4, 1'b1, 16'h0180, 4'b1010},
        {OTH, 4'h0, 6'd0,  4'h0, 1'b0, 16'h2800, 4'b0000},
        {OTH, 4'h0, 6'd0,  4'h0, 1'b1, 16'h5AC3, 4'b0010}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [4:0] dev_id = DEV, col = '0;
    logic [2:0] rtr = 3'd2;
    logic cmd_v, mask_v, orph, xcmd_v;
    logic [3:0] cmd_bank, cmd_op, mask_bank, xcmd_bank;
    logic [5:0] cmd_col, mask_col;
    logic [15:0] mask_we;
    logic [4:0] xcmd_op;
    int n_chk = 0, n_bad = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    col_rx u_dut (
        .clk(clk), .rst_n(rst_n), .dev_id_i(dev_id), .rtr_slots_i(rtr), .col_i(col),
        .cmd_valid_o(cmd_v), .cmd_bank_o(cmd_bank), .cmd_col_o(cmd_col), .cmd_op_o(cmd_op),
        .mask_valid_o(mask_v), .mask_we_o(mask_we), .mask_bank_o(mask_bank),
        .mask_col_o(mask_col), .mask_orphan_o(orph), .xcmd_valid_o(xcmd_v),
        .xcmd_bank_o(xcmd_bank), .xcmd_op_o(xcmd_op)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic [39:0] mk(logic [4:0] d, logic [3:0] b, logic [5:0] c,
                                       logic [3:0] op, logic m, logic [15:0] pay);
        return {1'b1, d, 1'b0, b, 2'b00, c, op, m, pay};
    endfunction

    // Drive one frame, one sample per clock, changed at the falling edge.
    task automatic send(logic [39:0] p);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            col = p[39-5*k -: 5];
            @(posedge clk);
        end
    endtask

    // Idle the lane and move to the cycle where the strobes are visible.
    task automatic settle();
        @(negedge clk);
        col = '0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic strobes(string tag, logic [3:0] exp);
        check(tag, {cmd_v, xcmd_v, mask_v, orph}, exp);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic       hv [4];
        logic [3:0] hb [4];
        logic [5:0] hc [4];
        for (int i = 0; i < 4; i++) begin hv[i] = 1'b0; hb[i] = '0; hc[i] = '0; end

        repeat (3) @(posedge clk);
        @(negedge clk);
        strobes("R11 reset strobes", 4'b0000);
        rst_n = 1'b1;

        // Table walk with rtr=2 and a bench-side write history.
        for (int i = 0; i < NV; i++) begin
            logic [4:0] cd; logic [3:0] cb, cop; logic [5:0] cc;
            logic m; logic [15:0] pay; logic [3:0] ex;
            {cd, cb, cc, cop, m, pay, ex} = VEC[i];
            send(mk(cd, cb, cc, cop, m, pay));
            settle();
            strobes($sformatf("R3 R6 R8 vector %0d strobes", i), ex);
            if (ex[3]) check($sformatf("R2 vector %0d cmd fields", i),
                             {cmd_bank, cmd_col, cmd_op}, {cb, cc, cop});
            if (ex[2]) check($sformatf("R5 vector %0d xcmd fields", i),
                             {xcmd_bank, xcmd_op}, {pay[9:6], pay[5:1]});
            if (m) check($sformatf("R9 vector %0d model pairing", i),
                         {30'd0, mask_v, orph}, {30'd0, hv[1], !hv[1]});
            if (ex[1]) check($sformatf("R7 vector %0d mask fields", i),
                             {mask_we, mask_bank, mask_col}, {pay[7:0], pay[15:8], hb[1], hc[1]});
            for (int s = 3; s > 0; s--) begin hv[s] = hv[s-1]; hb[s] = hb[s-1]; hc[s] = hc[s-1]; end
            hv[0] = (cd == DEV) && (cop == 4'h4); hb[0] = cb; hc[0] = cc;
        end

        // R1: idle samples with the start bit low are ignored.
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); col = 5'h0F;
            @(posedge clk);
        end
        @(negedge clk);
        strobes("R1 idle garbage no strobe", 4'b0000);
        send(mk(DEV, 4'hA, 6'd33, 4'h2, 1'b0, 16'h2800));
        settle();
        strobes("R1 frame after garbage", 4'b1000);
        check("R1 fields after garbage", {cmd_bank, cmd_col, cmd_op}, {4'hA, 6'd33, 4'h2});

        // R4: reserved bits set everywhere, both parts addressed to us.
        send(mk(DEV, 4'h6, 6'd18, 4'h3, 1'b0, {DEV, 1'b0, 4'h5, 5'h11, 1'b0}) | 40'h0218000401);
        settle();
        strobes("R4 reserved frame strobes", 4'b1100);
        check("R4 reserved cmd fields", {cmd_bank, cmd_col, cmd_op}, {4'h6, 6'd18, 4'h3});
        check("R4 reserved xcmd fields", {xcmd_bank, xcmd_op}, {4'h5, 5'h11});

        // R4: other device column command gives no strobe.
        send(mk(OTH, 4'h6, 6'd18, 4'h3, 1'b0, 16'h2800));
        settle();
        strobes("R4 other device", 4'b0000);

        // R1 and R7: back-to-back frames, rtr=1, mask pairs the directly previous write.
        rtr = 3'd1;
        send(mk(DEV, 4'h1, 6'd44, 4'h4, 1'b0, 16'h2800));
        send(mk(OTH, 4'h0, 6'd0, 4'h0, 1'b1, 16'h1234));
        settle();
        strobes("R1 back-to-back second frame", 4'b0010);
        check("R7 rtr1 mask fields", {mask_we, mask_bank, mask_col}, {16'h3412, 4'h1, 6'd44});

        // R10: rtr=0 behaves as 1.
        rtr = 3'd0;
        send(mk(DEV, 4'h4, 6'd4, 4'h4, 1'b0, 16'h2800));
        settle();
        send(mk(OTH, 4'h0, 6'd0, 4'h0, 1'b1, 16'h00FF));
        settle();
        strobes("R10 rtr0 as 1", 4'b0010);
        check("R10 rtr0 bank col", {mask_bank, mask_col}, {4'h4, 6'd4});

        // R10: rtr=7 behaves as 4.
        rtr = 3'd7;
        send(mk(DEV, 4'hC, 6'd12, 4'h4, 1'b0, 16'h2800));
        settle();
        for (int f = 0; f < 3; f++) begin
            send(mk(OTH, 4'h0, 6'd0, 4'h0, 1'b0, 16'h2800));
            settle();
        end
        send(mk(OTH, 4'h0, 6'd0, 4'h0, 1'b1, 16'hF00F));
        settle();
        strobes("R10 rtr7 as 4", 4'b0010);
        check("R10 rtr7 bank col", {mask_bank, mask_col}, {4'hC, 6'd12});

        // R11: a pending write is dropped by reset; next mask is an orphan.
        rtr = 3'd1;
        send(mk(DEV, 4'h7, 6'd7, 4'h4, 1'b0, 16'h2800));
        settle();
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        strobes("R11 strobes in reset", 4'b0000);
        rst_n = 1'b1;
        send(mk(OTH, 4'h0, 6'd0, 4'h0, 1'b1, 16'hFFFF));
        settle();
        strobes("R11 orphan after reset", 4'b0001);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule